// File: doc/BRIEF.md
# Fixed-Period Fan PWM Generator

This block drives a single fan through one pulse-width-modulated output whose period is fixed at 40 ms. The period is counted in cycles of the block's own clock, whose frequency is a parameter. Software programs the block through a small synchronous register bus with 32-bit registers on a 4-byte stride. A control word holds an on/off bit, a fan-wiring mode bit and an 8-bit duty value. A second word holds a 16-bit maximum fan-speed value, which is stored for software and does not affect the output.

Every period opens with the output high. The output stays high for floor(duty × period / 255) clock cycles and is low for the rest of the period. A duty of 255 therefore holds the output high for the whole period. A new duty value acts on the very next clock, with no wait for the period to end. Turning the block off drives the output low and clears the period position, so turning it back on begins a new period.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After synchronous reset, the control word at offset 0x0 reads 0 (off, mode 0, duty 0). The speed word at offset 0x4 reads 4000 (0x0FA0). The output is low.
- R2: A read (select high, write low) returns its data on `bus_rdata` in the cycle after the request. In any cycle that follows a clock with no read request, `bus_rdata` is 0.
- R3: In the control word, bit 0 is the on bit, bit 1 is the mode bit and bits 23:16 are the duty. These bits read back as written. All other bits read 0 and ignore writes.
- R4: Bits 15:0 of the speed word are read/write and hold values up to 65535. Bits 31:16 read 0.
- R5: A write to any offset other than 0x0 and 0x4 changes nothing. A read from any such offset returns 0.
- R6: While the block is on, the period is exactly PERIOD_CYC clocks. Each period begins with the output high. The output is high for floor(duty × PERIOD_CYC / 255) clocks, all of them at the start of the period.
- R7: A duty of 0 keeps the output constantly low. A duty of 255 keeps it constantly high while the block is on.
- R8: The clock edge that writes the on bit as 0 drives the output low. The output stays low while the block is off. A later switch-on starts a new period at position 0.
- R9: A duty write made in the middle of a period sets the output level against the new duty from the next clock on.
- R10: The mode bit is storage only. The output waveform is the same whether the mode bit is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the time base for the period |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pwm_out | output | 1 | Fan drive, active high |

## Verification
The hardest case to reach from the ports is a duty change that lands at a chosen position inside a running period. The bench tracks the period position by counting clocks from the enabling write. It issues the new duty at a known position where the output is already low, then checks that the output goes high on the next clock and that the shortened remainder and the following full period hold the expected number of high cycles. A small clock parameter makes the period 360 cycles. This lets the bench sweep all 256 duty values and compare the measured high time, and the position of the falling edge, against floor(duty × 360 / 255).

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

    localparam int unsigned FP_OFF_CTRL  = 32'h0;
    localparam int unsigned FP_OFF_SPEED = 32'h4;

    localparam logic [15:0] FP_SPEED_RESET = 16'd4000;
    localparam int unsigned FP_DUTY_FULL   = 255;

    typedef struct packed {
        logic [7:0] duty;
        logic       mode;
        logic       on;
    } fan_ctrl_t;

    typedef enum logic [1:0] {
        FP_HIT_NONE,
        FP_HIT_CTRL,
        FP_HIT_SPEED
    } fan_hit_e;

    function automatic logic [31:0] pack_ctrl(input fan_ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.on;
        w[1]     = c.mode;
        w[23:16] = c.duty;
        return w;
    endfunction

    function automatic fan_ctrl_t unpack_ctrl(input logic [31:0] w);
        fan_ctrl_t c;
        c.on   = w[0];
        c.mode = w[1];
        c.duty = w[23:16];
        return c;
    endfunction

    function automatic logic [31:0] pack_speed(input logic [15:0] s);
        return {16'h0, s};
    endfunction

endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output fan_ctrl_t         ctrl
);

    fan_ctrl_t   ctrl_q;
    logic [15:0] speed_q;
    logic [31:0] rdata_q;
    fan_hit_e    hit;
    logic [31:0] rd_mux;
    logic        wdata_unused;

    assign wdata_unused = ^bus_wdata[31:24];

    always_comb begin
        if (bus_addr == ADDR_W'(FP_OFF_CTRL))
            hit = FP_HIT_CTRL;
        else if (bus_addr == ADDR_W'(FP_OFF_SPEED))
            hit = FP_HIT_SPEED;
        else
            hit = FP_HIT_NONE;
    end

    always_comb begin
        unique case (hit)
            FP_HIT_CTRL:  rd_mux = pack_ctrl(ctrl_q);
            FP_HIT_SPEED: rd_mux = pack_speed(speed_q);
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            speed_q <= FP_SPEED_RESET;
            rdata_q <= '0;
        end else begin
            if (bus_sel && bus_wr) begin
                if (hit == FP_HIT_CTRL)
                    ctrl_q <= unpack_ctrl(bus_wdata);
                if (hit == FP_HIT_SPEED)
                    speed_q <= bus_wdata[15:0];
            end
            rdata_q <= (bus_sel && !bus_wr) ? rd_mux : '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign ctrl      = ctrl_q;

endmodule

// File: rtl/fan_pwm_scale.sv
module fan_pwm_scale
    import fan_pwm_pkg::*;
#(
    parameter int CNT_W      = 22,
    parameter int PERIOD_CYC = 4000000
) (
    input  logic [7:0]     duty,
    output logic [CNT_W:0] high_len
);

    localparam int PROD_W = CNT_W + 9;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        prod     = PROD_W'(duty) * PROD_W'(PERIOD_CYC);
        quot     = prod / PROD_W'(FP_DUTY_FULL);
        high_len = quot[CNT_W:0];
    end

endmodule

// File: rtl/fan_pwm_wave.sv
module fan_pwm_wave #(
    parameter int CNT_W      = 22,
    parameter int PERIOD_CYC = 4000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             on,
    input  logic [CNT_W:0]   high_len,
    output logic [CNT_W-1:0] pos,
    output logic             wave
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || !on)
            pos_q <= '0;
        else if (pos_q == LAST)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    assign pos  = pos_q;
    assign wave = on && ({1'b0, pos_q} < high_len);

endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CLK_HZ    = 100000000,
    parameter int PERIOD_US = 40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);

    localparam longint PERIOD_L   = (longint'(CLK_HZ) * longint'(PERIOD_US)) / 64'd1000000;
    localparam int     PERIOD_CYC = int'(PERIOD_L);
    localparam int     CNT_W      = $clog2(PERIOD_CYC);

    fan_ctrl_t        ctrl;
    logic             en_q;
    logic [7:0]       duty_q;
    logic [CNT_W:0]   high_len;
    logic [CNT_W-1:0] cnt_q;

    fan_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl)
    );

    assign en_q   = ctrl.on;
    assign duty_q = ctrl.duty;

    fan_pwm_scale #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC)) u_scale (
        .duty     (duty_q),
        .high_len (high_len)
    );

    fan_pwm_wave #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC)) u_wave (
        .clk      (clk),
        .rst      (rst),
        .on       (en_q),
        .high_len (high_len),
        .pos      (cnt_q),
        .wave     (pwm_out)
    );

endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 22,
    parameter int PERIOD_CYC = 4000000
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              pwm_out,
    input logic              en_q,
    input logic [7:0]        duty_q,
    input logic [CNT_W-1:0]  cnt_q
);

    logic ctrl_off_wr;
    logic stray_wr;

    assign ctrl_off_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(0)) && !bus_wdata[0];
    assign stray_wr    = bus_sel && bus_wr && (bus_addr != ADDR_W'(0)) && (bus_addr != ADDR_W'(4));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt_q == '0 && !pwm_out && !en_q));

    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> (bus_rdata == 32'h0));

    // R5
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        stray_wr |=> ($stable(en_q) && $stable(duty_q)));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt_q} < (CNT_W+1)'(PERIOD_CYC)));

    // R6
    period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && cnt_q == CNT_W'(PERIOD_CYC - 1)) |=> (cnt_q == '0));

    // R6
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && cnt_q == '0 && duty_q != 8'd0) |-> pwm_out);

    // R7
    zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_q == 8'd0) |-> !pwm_out);

    // R7
    full_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && duty_q == 8'd255) |-> pwm_out);

    // R8
    off_write_low_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_off_wr |=> !pwm_out);

    // R8
    off_hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (cnt_q == '0));

endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .PERIOD_CYC (PERIOD_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .en_q      (en_q),
    .duty_q    (duty_q),
    .cnt_q     (cnt_q)
);

// File: tb/fan_pwm_ctrl_test.sv
`timescale 1ns/1ps
module fan_pwm_ctrl_test;

    localparam int ADDR_W = 4;
    localparam int CLK_HZ = 9000;
    localparam int P      = 360;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              pwm_out;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    fan_pwm_ctrl #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ), .PERIOD_US(40000)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all tasks are entered and left at a falling edge
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic count_high(input int n, output int highs, output int first_low);
        highs = 0;
        first_low = n;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            else if (first_low == n) first_low = i;
            @(negedge clk);
        end
    endtask

    function automatic int exp_high(input int d);
        return (d * P) / 255;
    endfunction

    function automatic logic [31:0] ctrl_word(input int d, input bit on, input bit mode);
        return {8'h0, 8'(d), 14'h0, mode, on};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int hi, fl;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pwm after reset", pwm_out, 0);
        bus_read(4'h0, rd);
        check("R1 ctrl reset", rd, 0);
        bus_read(4'h4, rd);
        check("R1 speed reset", rd, 4000);
        // R2 data only in the cycle after a read
        @(negedge clk);
        check("R2 idle rdata", bus_rdata, 0);

        // R3 control field layout
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, rd);
        check("R3 ctrl all ones", rd, 32'h00FF_0003);
        bus_write(4'h0, 32'h00A5_0002);
        bus_read(4'h0, rd);
        check("R3 ctrl pattern", rd, 32'h00A5_0002);
        bus_write(4'h0, 32'h0);

        // R4 speed width
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, rd);
        check("R4 speed max", rd, 32'h0000_FFFF);
        bus_write(4'h4, 32'h1234_5678);
        bus_read(4'h4, rd);
        check("R4 speed pattern", rd, 32'h0000_5678);

        // R5 unmapped offsets
        bus_write(4'h0, ctrl_word(0, 1'b0, 1'b1));
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_write(4'h2, 32'hFFFF_FFFF);
        bus_read(4'h0, rd);
        check("R5 ctrl untouched", rd, ctrl_word(0, 1'b0, 1'b1));
        bus_read(4'h4, rd);
        check("R5 speed untouched", rd, 32'h5678);
        check("R5 pwm untouched", pwm_out, 0);
        bus_read(4'h8, rd);
        check("R5 read 0x8", rd, 0);
        bus_read(4'h1, rd);
        check("R5 read 0x1", rd, 0);
        bus_write(4'h0, 32'h0);

        // R6 / R7 sweep of every duty value
        for (int d = 0; d < 256; d++) begin
            bus_write(4'h0, 32'h0);
            bus_write(4'h0, ctrl_word(d, 1'b1, 1'b0));
            count_high(P, hi, fl);
            if (d == 0 || d == 255)
                check($sformatf("R7 duty %0d high", d), hi, exp_high(d));
            else
                check($sformatf("R6 duty %0d high", d), hi, exp_high(d));
            check($sformatf("R6 duty %0d fall pos", d), fl, exp_high(d));
        end
        // R6 second period repeats
        count_high(P, hi, fl);
        check("R6 second period", hi, P);

        // R8 switch off forces low and restarts period
        bus_write(4'h0, ctrl_word(255, 1'b1, 1'b0));
        count_high(100, hi, fl);
        bus_write(4'h0, ctrl_word(255, 1'b0, 1'b0));
        count_high(20, hi, fl);
        check("R8 low while off", hi, 0);
        bus_write(4'h0, ctrl_word(128, 1'b1, 1'b0));
        count_high(P, hi, fl);
        check("R8 fresh period high", hi, exp_high(128));
        check("R8 fresh period fall", fl, exp_high(128));

        // R9 mid-period duty change
        bus_write(4'h0, 32'h0);
        bus_write(4'h0, ctrl_word(50, 1'b1, 1'b0));
        count_high(100, hi, fl);
        check("R9 old duty part", hi, exp_high(50));
        bus_write(4'h0, ctrl_word(200, 1'b1, 1'b0));
        check("R9 high next clock", pwm_out, 1);
        count_high(P - 101, hi, fl);
        check("R9 rest of period", hi, exp_high(200) - 101);
        count_high(P, hi, fl);
        check("R9 next full period", hi, exp_high(200));

        // R10 mode bit has no effect on output
        bus_write(4'h0, 32'h0);
        bus_write(4'h0, ctrl_word(77, 1'b1, 1'b1));
        count_high(P, hi, fl);
        check("R10 mode1 high", hi, exp_high(77));
        check("R10 mode1 fall", fl, exp_high(77));

        summary();
        $finish;
    end

endmodule